// File: doc/BRIEF.md
# Playback Format Decoder and Sample Expander

This block holds the playback format byte of an audio output path and turns it into the parameters the rest of the path needs. From the byte it derives the sample rate in hertz, whether the stream is mono or stereo, which sample encoding is in use, and a shift that converts a count of sample periods into a count of bytes. Rate codes that have no rate, reserved encodings and the 4-bit ADPCM encoding are reported through an error flag. While that flag is set, the sample stream is held stopped.

The block also sits in the byte path between the memory fetch logic and the output stage. Bytes arrive on a valid/ready input. Each companded byte (mu-law or A-law) is expanded by arithmetic into a signed 16-bit sample. An unsigned 8-bit byte is widened with a zero upper byte. For the 16-bit encodings, two bytes are joined into one sample, in the byte order that the encoding selects. Samples leave on a valid/ready output with a single register stage. Loading a new format byte flushes any half-built sample and any sample still waiting at the output.

Top module: `pbfmt_expander`

## Requirements
- R1: A high `fmt_load` at a clock edge captures `fmt_byte` and `wide_codes`. All decoded outputs follow from the captured values from the next cycle on. After reset the captured values are byte 0x00 with `wide_codes` low, which decodes to 8000 Hz, mono, encoding 0, shift 0 and no error.
- R2: Bit 0 of the format byte picks one of two rate tables, and bits 3:1 index it. Table 0 holds 8000, 16000, 27420, 32000, none, none, 48000 and 9000. Table 1 holds 5510, 11025, 18900, 22050, 37800, 44100, 33075 and 6620. An entry with no rate gives `rate_hz` = 0 and sets `fmt_err`.
- R3: `stereo` equals bit 4 of the format byte.
- R4: `enc_code` is bits 6:5 of the format byte, zero-extended, when `wide_codes` was low at load. It is bits 7:5 when `wide_codes` was high. The codes are: 0 unsigned 8-bit, 1 mu-law, 2 signed 16-bit little-endian, 3 A-law, 5 ADPCM, 6 signed 16-bit big-endian, and 4 and 7 reserved. Codes 4, 5 and 7 set `fmt_err`.
- R5: `cnt_shift` depends on the encoding. For codes 2 and 6 it is 2 for stereo and 1 for mono. For every other code it is 1 for stereo and 0 for mono.
- R6: With code 0, each accepted byte b produces the sample {8'h00, b}.
- R7: With code 2, two accepted bytes produce one sample, and the first byte is the low half. With code 6, the first byte is the high half.
- R8: With code 1, each byte is mu-law expanded. Byte 0x00 gives -32124, byte 0x80 gives +32124, and bytes 0x7F and 0xFF give 0. Every byte matches the segment/mantissa mu-law expansion.
- R9: With code 3, each byte is A-law expanded. Byte 0x00 gives -5504, byte 0x80 gives +5504, byte 0x55 gives -8 and byte 0xD5 gives +8. Every byte matches the segment/mantissa A-law expansion.
- R10: While `fmt_err` is high, `in_ready` and `out_valid` are low.
- R11: `in_ready` is high exactly when there is no error, no load, and the output register is empty or being taken. A sample that is offered and not taken holds `out_valid` and `out_data` steady.
- R12: `fmt_load` drops `in_ready` in its own cycle. It clears `out_valid` and discards a half-assembled 16-bit pair.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| fmt_load | input | 1 | Capture a new format byte |
| fmt_byte | input | 8 | Playback format byte |
| wide_codes | input | 1 | Use the 3-bit encoding field (extended mode) |
| in_valid | input | 1 | Input byte valid |
| in_data | input | 8 | Input byte |
| in_ready | output | 1 | Input byte accepted when valid |
| out_valid | output | 1 | Output sample valid |
| out_data | output | 16 | Output sample |
| out_ready | input | 1 | Downstream takes the sample |
| rate_hz | output | 16 | Decoded sample rate in hertz, 0 when invalid |
| stereo | output | 1 | Two channels |
| enc_code | output | 3 | Decoded encoding code |
| cnt_shift | output | 2 | Sample-period-to-byte count shift |
| fmt_err | output | 1 | Invalid rate, reserved code or ADPCM |

## Verification
The assertions assume that the upstream source keeps a byte on `in_data` until it is accepted. They also assume that a format load is the only event that changes the encoding, so a half-built pair can only exist under a 16-bit code and an error can only appear together with a flush. The stimulus drives bytes only while `in_ready` is seen high at mid-cycle. It always leaves the input idle around a load. It randomizes `out_ready` during streams, but sends stream bytes only under formats that decode without error. Error formats are probed with `in_valid` held high, so the stall can be observed at the ports.

// File: rtl/pbfmt_pkg.sv
package pbfmt_pkg;
  localparam int BYTE_W   = 8;
  localparam int SAMPLE_W = 2 * BYTE_W;
  localparam int RATE_W   = 16;
  localparam int CODE_W   = 3;

  typedef enum logic [CODE_W-1:0] {
    ENC_U8    = 3'd0,
    ENC_MULAW = 3'd1,
    ENC_S16LE = 3'd2,
    ENC_ALAW  = 3'd3,
    ENC_RSV4  = 3'd4,
    ENC_ADPCM = 3'd5,
    ENC_S16BE = 3'd6,
    ENC_RSV7  = 3'd7
  } enc_e;

  typedef struct packed {
    logic [RATE_W-1:0] rate;
    logic              stereo;
    enc_e              enc;
    logic [1:0]        shift;
    logic              err;
  } fmt_info_t;

  function automatic logic [RATE_W-1:0] rate_lookup(input logic xtal,
                                                    input logic [2:0] idx);
    logic [RATE_W-1:0] r;
    case ({xtal, idx})
      4'b0_000: r = 16'd8000;
      4'b0_001: r = 16'd16000;
      4'b0_010: r = 16'd27420;
      4'b0_011: r = 16'd32000;
      4'b0_110: r = 16'd48000;
      4'b0_111: r = 16'd9000;
      4'b1_000: r = 16'd5510;
      4'b1_001: r = 16'd11025;
      4'b1_010: r = 16'd18900;
      4'b1_011: r = 16'd22050;
      4'b1_100: r = 16'd37800;
      4'b1_101: r = 16'd44100;
      4'b1_110: r = 16'd33075;
      4'b1_111: r = 16'd6620;
      default:  r = '0;
    endcase
    return r;
  endfunction

  function automatic logic enc_is_wide(input enc_e e);
    return (e == ENC_S16LE) || (e == ENC_S16BE);
  endfunction
endpackage

// File: rtl/pbfmt_decode.sv
module pbfmt_decode
  import pbfmt_pkg::*;
(
  input  logic [BYTE_W-1:0] fmt_byte,
  input  logic              wide_codes,
  output fmt_info_t         info
);
  logic [2:0] rate_idx;
  logic       xtal;
  enc_e       enc;
  logic       code_bad;
  logic       rate_bad;

  always_comb begin
    xtal     = fmt_byte[0];
    rate_idx = fmt_byte[3:1];
    enc      = enc_e'(wide_codes ? fmt_byte[7:5] : {1'b0, fmt_byte[6:5]});
    code_bad = (enc == ENC_RSV4) || (enc == ENC_ADPCM) || (enc == ENC_RSV7);

    info.rate   = rate_lookup(xtal, rate_idx);
    rate_bad    = (info.rate == '0);
    info.stereo = fmt_byte[4];
    info.enc    = enc;
    if (enc_is_wide(enc)) info.shift = fmt_byte[4] ? 2'd2 : 2'd1;
    else                  info.shift = fmt_byte[4] ? 2'd1 : 2'd0;
    info.err    = rate_bad || code_bad;
  end
endmodule

// File: rtl/pbfmt_law_expand.sv
module pbfmt_law_expand
  import pbfmt_pkg::*;
#(
  parameter bit IS_ALAW = 1'b0
) (
  input  logic [BYTE_W-1:0]   code_in,
  output logic [SAMPLE_W-1:0] lin_out
);
  generate
    if (IS_ALAW) begin : g_alaw
      logic [BYTE_W-1:0]   a;
      logic [2:0]          seg;
      logic [SAMPLE_W-1:0] base;
      logic [SAMPLE_W-1:0] mag;
      always_comb begin
        a    = code_in ^ 8'h55;
        seg  = a[6:4];
        base = SAMPLE_W'({a[3:0], 4'b0000});
        if (seg == 3'd0) mag = base + 16'd8;
        else             mag = (base + 16'd264) << (seg - 3'd1);
        lin_out = a[7] ? mag : (16'd0 - mag);
      end
    end else begin : g_mulaw
      logic [BYTE_W-1:0]   u;
      logic [SAMPLE_W-1:0] t;
      always_comb begin
        u       = ~code_in;
        t       = (SAMPLE_W'({u[3:0], 3'b000}) + 16'd132) << u[6:4];
        lin_out = u[7] ? (16'd132 - t) : (t - 16'd132);
      end
    end
  endgenerate
endmodule

// File: rtl/pbfmt_assemble.sv
module pbfmt_assemble
  import pbfmt_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  enc_e                enc,
  input  logic                err,
  input  logic                flush,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_data,
  output logic                in_ready,
  input  logic [SAMPLE_W-1:0] mu_val,
  input  logic [SAMPLE_W-1:0] a_val,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  input  logic                out_ready
);
  logic                half_q, half_n;
  logic [BYTE_W-1:0]   hold_q, hold_n;
  logic                ov_q, ov_n;
  logic [SAMPLE_W-1:0] od_q, od_n;
  logic                accept;
  logic                wide;
  logic [SAMPLE_W-1:0] sample;

  always_comb begin
    wide     = enc_is_wide(enc);
    in_ready = !err && !flush && (!ov_q || out_ready);
    accept   = in_valid && in_ready;
    case (enc)
      ENC_U8:    sample = {8'h00, in_data};
      ENC_MULAW: sample = mu_val;
      ENC_ALAW:  sample = a_val;
      ENC_S16LE: sample = {in_data, hold_q};
      ENC_S16BE: sample = {hold_q, in_data};
      default:   sample = '0;
    endcase
  end

  always_comb begin
    half_n = half_q;
    hold_n = hold_q;
    ov_n   = ov_q;
    od_n   = od_q;
    if (flush) begin
      half_n = 1'b0;
      ov_n   = 1'b0;
    end else begin
      if (ov_q && out_ready) ov_n = 1'b0;
      if (accept) begin
        if (wide && !half_q) begin
          half_n = 1'b1;
          hold_n = in_data;
        end else begin
          half_n = 1'b0;
          ov_n   = 1'b1;
          od_n   = sample;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      half_q <= 1'b0;
      hold_q <= '0;
      ov_q   <= 1'b0;
      od_q   <= '0;
    end else begin
      half_q <= half_n;
      hold_q <= hold_n;
      ov_q   <= ov_n;
      od_q   <= od_n;
    end
  end

  assign out_valid = ov_q;
  assign out_data  = od_q;

  // R11: a stalled sample stays put
  p_stall_hold_r11: assert property (@(posedge clk) disable iff (!rst_n)
    (ov_q && !out_ready && !flush) |=> (ov_q && $stable(od_q)));

  // R7: a pending half only exists under a 16-bit code
  p_half_wide_r7: assert property (@(posedge clk) disable iff (!rst_n)
    half_q |-> wide);
endmodule

// File: rtl/pbfmt_expander.sv
module pbfmt_expander
  import pbfmt_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_load,
  input  logic [BYTE_W-1:0]   fmt_byte,
  input  logic                wide_codes,
  input  logic                in_valid,
  input  logic [BYTE_W-1:0]   in_data,
  output logic                in_ready,
  output logic                out_valid,
  output logic [SAMPLE_W-1:0] out_data,
  input  logic                out_ready,
  output logic [RATE_W-1:0]   rate_hz,
  output logic                stereo,
  output logic [CODE_W-1:0]   enc_code,
  output logic [1:0]          cnt_shift,
  output logic                fmt_err
);
  logic [SYNC_STAGES-1:0] rs_q;
  logic                   rst_ns;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= '0;
    else        rs_q <= {rs_q[SYNC_STAGES-2:0], 1'b1};
  end
  assign rst_ns = rs_q[SYNC_STAGES-1];

  logic [BYTE_W-1:0] fmt_q, fmt_n;
  logic              wide_q, wide_n;

  always_comb begin
    fmt_n  = fmt_q;
    wide_n = wide_q;
    if (fmt_load) begin
      fmt_n  = fmt_byte;
      wide_n = wide_codes;
    end
  end

  always_ff @(posedge clk or negedge rst_ns) begin
    if (!rst_ns) begin
      fmt_q  <= '0;
      wide_q <= 1'b0;
    end else begin
      fmt_q  <= fmt_n;
      wide_q <= wide_n;
    end
  end

  fmt_info_t info;

  pbfmt_decode u_decode (
    .fmt_byte   (fmt_q),
    .wide_codes (wide_q),
    .info       (info)
  );

  logic [SAMPLE_W-1:0] mu_val;
  logic [SAMPLE_W-1:0] a_val;

  pbfmt_law_expand #(.IS_ALAW(1'b0)) u_mulaw (
    .code_in (in_data),
    .lin_out (mu_val)
  );

  pbfmt_law_expand #(.IS_ALAW(1'b1)) u_alaw (
    .code_in (in_data),
    .lin_out (a_val)
  );

  pbfmt_assemble u_asm (
    .clk       (clk),
    .rst_n     (rst_ns),
    .enc       (info.enc),
    .err       (info.err),
    .flush     (fmt_load),
    .in_valid  (in_valid),
    .in_data   (in_data),
    .in_ready  (in_ready),
    .mu_val    (mu_val),
    .a_val     (a_val),
    .out_valid (out_valid),
    .out_data  (out_data),
    .out_ready (out_ready)
  );

  assign rate_hz   = info.rate;
  assign stereo    = info.stereo;
  assign enc_code  = info.enc;
  assign cnt_shift = info.shift;
  assign fmt_err   = info.err;

  // R10: no sample leaves while the format is in error
  p_err_silent_r10: assert property (@(posedge clk) disable iff (!rst_ns)
    fmt_err |-> (!out_valid && !in_ready));

  // R12: a load empties the output register
  p_load_flush_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    fmt_load |=> !out_valid);

  // R12: no byte is taken in a load cycle
  p_load_block_r12: assert property (@(posedge clk) disable iff (!rst_ns)
    fmt_load |-> !in_ready);

  // R1: decoded outputs change only after a load
  p_fmt_steady_r1: assert property (@(posedge clk) disable iff (!rst_ns)
    !fmt_load |=> ($stable(rate_hz) && $stable(enc_code) && $stable(stereo)));
endmodule

// File: tb/pbfmt_expander_test.sv
module pbfmt_expander_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_load = 1'b0;
  logic [7:0]  fmt_byte = 8'h00;
  logic        wide_codes = 1'b0;
  logic        in_valid = 1'b0;
  logic [7:0]  in_data = 8'h00;
  logic        in_ready;
  logic        out_valid;
  logic [15:0] out_data;
  logic        out_ready = 1'b1;
  logic [15:0] rate_hz;
  logic        stereo;
  logic [2:0]  enc_code;
  logic [1:0]  cnt_shift;
  logic        fmt_err;

  pbfmt_expander uut (
    .clk(clk), .rst_n(rst_n), .fmt_load(fmt_load), .fmt_byte(fmt_byte),
    .wide_codes(wide_codes), .in_valid(in_valid), .in_data(in_data),
    .in_ready(in_ready), .out_valid(out_valid), .out_data(out_data),
    .out_ready(out_ready), .rate_hz(rate_hz), .stereo(stereo),
    .enc_code(enc_code), .cnt_shift(cnt_shift), .fmt_err(fmt_err)
  );

  always #5 clk = ~clk;

  int total = 0;
  int bad = 0;
  int cycles = 0;
  bit live = 1'b0;
  bit ended = 1'b0;
  int cur_enc = 0;
  string cur_req = "R6";
  logic [15:0] exp_q[$];
  bit   pend_v = 1'b0;
  logic [7:0] pend_b = 8'h00;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic int ref_rate(input logic [7:0] b);
    int t0[8] = '{8000, 16000, 27420, 32000, 0, 0, 48000, 9000};
    int t1[8] = '{5510, 11025, 18900, 22050, 37800, 44100, 33075, 6620};
    return b[0] ? t1[b[3:1]] : t0[b[3:1]];
  endfunction

  function automatic int ref_enc(input logic [7:0] b, input bit ext);
    return ext ? int'(b[7:5]) : int'(b[6:5]);
  endfunction

  function automatic int ref_shift(input logic [7:0] b, input bit ext);
    int e = ref_enc(b, ext);
    if (e == 2 || e == 6) return b[4] ? 2 : 1;
    return b[4] ? 1 : 0;
  endfunction

  function automatic bit ref_err(input logic [7:0] b, input bit ext);
    int e = ref_enc(b, ext);
    return (ref_rate(b) == 0) || e == 4 || e == 5 || e == 7;
  endfunction

  function automatic logic [15:0] ref_mu(input logic [7:0] b);
    int ex = (~b >> 4) & 7;
    int mn = ~b & 15;
    int mag = (((mn << 1) + 33) << (ex + 2)) - 132;
    return b[7] ? 16'(mag) : 16'(-mag);
  endfunction

  function automatic logic [15:0] ref_a(input logic [7:0] b);
    logic [7:0] x = b ^ 8'h55;
    int ex = x[6:4];
    int mn = x[3:0];
    int mag = (ex == 0) ? ((mn << 4) + 8) : (((mn << 4) + 264) << (ex - 1));
    return x[7] ? 16'(mag) : 16'(-mag);
  endfunction

  always @(negedge clk) begin
    #2;
    if (live && out_valid && out_ready) begin
      if (exp_q.size() == 0) check(1'b0, cur_req, int'(out_data), -1);
      else begin
        logic [15:0] e;
        e = exp_q.pop_front();
        check(out_data == e, cur_req, int'(out_data), int'(e));
      end
    end
  end

  task automatic finish_run();
    if (!ended) begin
      ended = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++;
      total++;
      $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150000);
      finish_run();
    end
  end

  task automatic load_fmt(input logic [7:0] b, input bit ext);
    @(negedge clk);
    fmt_load = 1'b1; fmt_byte = b; wide_codes = ext; in_valid = 1'b0;
    @(negedge clk);
    fmt_load = 1'b0;
    exp_q.delete();
    pend_v = 1'b0;
    cur_enc = ref_enc(b, ext);
    #1;
  endtask

  task automatic push_byte(input logic [7:0] b);
    @(negedge clk);
    out_ready = ($urandom % 4) != 0;
    in_valid = 1'b1; in_data = b;
    #1;
    while (!in_ready) begin
      @(negedge clk);
      out_ready = ($urandom % 4) != 0;
      #1;
    end
    case (cur_enc)
      0: exp_q.push_back({8'h00, b});
      1: exp_q.push_back(ref_mu(b));
      3: exp_q.push_back(ref_a(b));
      2, 6: begin
        if (!pend_v) begin pend_v = 1'b1; pend_b = b; end
        else begin
          pend_v = 1'b0;
          exp_q.push_back(cur_enc == 2 ? {b, pend_b} : {pend_b, b});
        end
      end
      default: ;
    endcase
  endtask

  task automatic drain();
    @(negedge clk);
    in_valid = 1'b0; out_ready = 1'b1;
    repeat (4) @(negedge clk);
    check(exp_q.size() == 0, cur_req, exp_q.size(), 0);
  endtask

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    live = 1'b1;
    #1;
    // R1 reset state
    check(rate_hz == 16'd8000, "R1", rate_hz, 8000);
    check(enc_code == 3'd0 && !stereo && cnt_shift == 2'd0, "R1", enc_code, 0);
    check(!fmt_err && !out_valid && in_ready, "R1", fmt_err, 0);

    // R2 R3 R4 R5 full sweep in both field widths
    for (int ext = 0; ext < 2; ext++) begin
      for (int b = 0; b < 256; b++) begin
        load_fmt(8'(b), ext[0]);
        check(int'(rate_hz) == ref_rate(8'(b)), "R2", rate_hz, ref_rate(8'(b)));
        check(stereo == b[4], "R3", stereo, b[4]);
        check(int'(enc_code) == ref_enc(8'(b), ext[0]), "R4", enc_code, ref_enc(8'(b), ext[0]));
        check(int'(cnt_shift) == ref_shift(8'(b), ext[0]), "R5", cnt_shift, ref_shift(8'(b), ext[0]));
        check(fmt_err == ref_err(8'(b), ext[0]), "R4", fmt_err, ref_err(8'(b), ext[0]));
      end
    end

    // R6 unsigned 8-bit
    cur_req = "R6";
    load_fmt(8'h00, 1'b0);
    for (int i = 0; i < 40; i++) push_byte(8'($urandom));
    push_byte(8'h00); push_byte(8'hFF);
    drain();

    // R8 mu-law, every byte
    cur_req = "R8";
    load_fmt(8'h21, 1'b0);
    for (int i = 0; i < 256; i++) push_byte(8'(i));
    drain();

    // R9 A-law, every byte
    cur_req = "R9";
    load_fmt(8'h60, 1'b0);
    for (int i = 0; i < 256; i++) push_byte(8'(i));
    drain();

    // R7 little-endian pairs
    cur_req = "R7";
    load_fmt(8'h5C, 1'b0);
    for (int i = 0; i < 40; i++) push_byte(8'($urandom));
    drain();

    // R7 big-endian pairs in the wide field
    load_fmt(8'hC3, 1'b1);
    for (int i = 0; i < 40; i++) push_byte(8'($urandom));
    drain();

    // R12 a half pair is discarded by a load
    cur_req = "R12";
    load_fmt(8'h40, 1'b0);
    push_byte(8'hAA);
    @(negedge clk); in_valid = 1'b0; out_ready = 1'b1;
    repeat (2) @(negedge clk);
    #1 check(!out_valid, "R12", out_valid, 0);
    load_fmt(8'h40, 1'b0);
    push_byte(8'h11); push_byte(8'h22);
    drain();

    // R11 stall keeps the sample and blocks input
    cur_req = "R11";
    load_fmt(8'h00, 1'b0);
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h5A;
    #1 check(in_ready, "R11", in_ready, 1);
    exp_q.push_back(16'h005A);
    @(negedge clk); in_valid = 1'b0;
    #1 check(out_valid && out_data == 16'h005A, "R11", out_data, 16'h005A);
    @(negedge clk);
    #1 check(out_valid && out_data == 16'h005A, "R11", out_data, 16'h005A);
    check(!in_ready, "R11", in_ready, 0);
    @(negedge clk); out_ready = 1'b1;
    @(negedge clk);
    #1 check(!out_valid && in_ready, "R11", out_valid, 0);

    // R12 pending output flushed by a load
    cur_req = "R12";
    @(negedge clk);
    out_ready = 1'b0; in_valid = 1'b1; in_data = 8'h33;
    @(negedge clk); in_valid = 1'b0;
    #1 check(out_valid, "R12", out_valid, 1);
    @(negedge clk);
    fmt_load = 1'b1; fmt_byte = 8'h00; wide_codes = 1'b0;
    #1 check(!in_ready, "R12", in_ready, 0);
    @(negedge clk); fmt_load = 1'b0;
    #1 check(!out_valid, "R12", out_valid, 0);
    out_ready = 1'b1;

    // R10 error formats hold the stream stopped
    load_fmt(8'h08, 1'b0);
    check(fmt_err, "R10", fmt_err, 1);
    @(negedge clk); in_valid = 1'b1; in_data = 8'h12;
    for (int i = 0; i < 4; i++) begin
      #1 check(!in_ready && !out_valid, "R10", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    load_fmt(8'hA0, 1'b1);
    check(fmt_err && enc_code == 3'd5, "R10", enc_code, 5);
    @(negedge clk); in_valid = 1'b1;
    for (int i = 0; i < 4; i++) begin
      #1 check(!in_ready && !out_valid, "R10", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    load_fmt(8'h00, 1'b0);
    check(!fmt_err && in_ready, "R10", in_ready, 1);

    finish_run();
  end
endmodule